// File: doc/BRIEF.md
# Interrupt Active-Priority Tracker

This block keeps the running priority of one CPU interface in a prioritized interrupt controller. Each time an interrupt is acknowledged, its 8-bit priority is cut down to a group priority using the binary point in force. The matching preemption level is then marked in one of two one-hot banks: one bank for group 0 and one for group 1. The running priority then takes the acknowledged group priority.

An end-of-interrupt clears the most urgent marked level of the interrupt's group. The running priority is then rebuilt by scanning both banks from the most urgent level downward. When nothing is marked, it returns to the idle value 0x100.

A small word-addressed register port lets software save and restore both banks. For a non-secure access under the security extension, the group-0 window shows part of the group-1 bank instead of the group-0 bank. Acknowledge and end-of-interrupt arrive as single-cycle strobes. The running priority is registered and reflects a strobe on the following cycle. Reads return data one cycle after the read strobe.

Top module: `actprio_tracker`

## Requirements
- R1: After reset `run_prio` is 0x100 and every bank word reads zero.
- R2: The group priority is `ack_prio` with its low (bp+1) bits cleared. Here bp is the selected binary point raised to at least MIN_BPR. A binary point of 7 gives a group priority of 0.
- R3: The aliased binary point `cfg_abpr` is used only when grouping is supported, `cfg_cbpr` is 0 and `ack_group1` is 1. In every other case `cfg_bpr` is used.
- R4: On `ack_valid`, the level L = group priority >> (MIN_BPR+1) is marked as bit L%32 of word L/32. The mark goes into the group-1 bank for a group-1 interrupt and into the group-0 bank otherwise. On the next cycle `run_prio` equals the group priority.
- R5: An accepted end-of-interrupt clears only the lowest set bit of the first nonzero word in the bank of its group (`eoi_group1`). `run_prio` then becomes (word*32 + lowest set bit of the OR of both banks) << (MIN_BPR+1), or 0x100 when both banks are empty.
- R6: An end-of-interrupt while `run_prio` is 0x100 changes nothing.
- R7: With the security extension, an end-of-interrupt with `eoi_nonsecure`=1 and `eoi_group1`=0 changes nothing.
- R8: For a secure access, byte address 0xD0+4n reaches group-0 word n and 0xE0+4n reaches group-1 word n. Any n at or beyond the implemented word count, and any other address, reads zero and ignores writes. `reg_rdata` is valid on the cycle after `reg_rd`, holds the bank contents from before any update made in the read cycle, and is zero when no read was made.
- R9: A non-secure access to 0xD0+4n maps into the group-1 bank, depending on MIN_BPR. With MIN_BPR 0, n<2 maps to word n+2. With MIN_BPR 1, n=0 maps to word 1. With MIN_BPR 2, n=0 maps to bits [31:16] of word 0, on data bits [15:0]. With MIN_BPR 3, n=0 maps to bits [15:8] of word 0, on data bits [7:0]. A write to a partial field leaves the other bits of word 0 unchanged. All other n read zero.
- R10: The group-1 window 0xE0–0xEC reads zero and ignores writes when grouping is absent, or when the access is non-secure under the security extension.
- R11: In a cycle, `ack_valid` takes precedence over `eoi_valid`, which is then ignored. A register write takes effect only when neither strobe is present. Register writes never change `run_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bpr | input | 3 | Binary point |
| cfg_abpr | input | 3 | Aliased binary point for group 1 |
| cfg_cbpr | input | 1 | 1: group 1 also uses `cfg_bpr` |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_group1 | input | 1 | Acknowledged interrupt is group 1 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_group1 | input | 1 | Completed interrupt is group 1 |
| eoi_nonsecure | input | 1 | End-of-interrupt issued by a non-secure access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_nonsecure | input | 1 | Register access is non-secure |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| run_prio | output | 9 | Running priority, 0x100 when idle |

## Verification
The bench first targets binary point corners: 7 wipes the priority, and a value below the minimum gets clamped. A wrong mask would leave stray low bits in the running priority, or mark the wrong level. It also checks when the aliased binary point is chosen, which exposes a swapped or always-applied alias. End-of-interrupt is driven while idle and as non-secure group 0. A design that dropped priority there would lose an active level. The non-secure group-0 window is written through its 16-bit field, so a write that clobbered the low half of the word shows up on a secure read of the group-1 bank. Random runs mix simultaneous strobes and writes, which catches a broken precedence or a write that disturbs the running priority.

// File: rtl/actprio_tracker.sv
module actprio_tracker #(
  parameter int MIN_BPR      = 2,
  parameter int HAS_GROUPS   = 1,
  parameter int HAS_SECURITY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_bpr,
  input  logic [2:0]  cfg_abpr,
  input  logic        cfg_cbpr,
  input  logic        ack_valid,
  input  logic [7:0]  ack_prio,
  input  logic        ack_group1,
  input  logic        eoi_valid,
  input  logic        eoi_group1,
  input  logic        eoi_nonsecure,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_nonsecure,
  output logic [31:0] reg_rdata,
  output logic [8:0]  run_prio
);
  localparam int LVL_SHIFT = MIN_BPR + 1;
  localparam int RAW_WORDS = (256 >> LVL_SHIFT) / 32;
  localparam int NWORDS    = (RAW_WORDS < 1) ? 1 : RAW_WORDS;
  localparam logic [8:0] IDLE    = 9'h100;
  localparam logic [8:0] LOWMASK = 9'((1 << LVL_SHIFT) - 1);

  logic [31:0] bank0_q [NWORDS];
  logic [31:0] bank1_q [NWORDS];
  logic [31:0] bank0_d [NWORDS];
  logic [31:0] bank1_d [NWORDS];
  logic [8:0]  rp_q, rp_d;
  logic [31:0] rdata_q, rdata_d;

  wire       use_alias = (HAS_GROUPS != 0) && !cfg_cbpr && ack_group1;
  wire [2:0] bp_raw    = use_alias ? cfg_abpr : cfg_bpr;
  wire [2:0] bp        = (int'(bp_raw) < MIN_BPR) ? 3'(MIN_BPR) : bp_raw;
  wire [3:0] cut       = {1'b0, bp} + 4'd1;
  wire [7:0] gprio     = ack_prio & (8'hFF << cut);
  wire [7:0] level     = gprio >> LVL_SHIFT;
  wire       ack_bank1 = (HAS_GROUPS != 0) && ack_group1;
  wire       eoi_bank1 = (HAS_GROUPS != 0) && eoi_group1;
  wire       eoi_ok    = eoi_valid && !ack_valid && (rp_q != IDLE) &&
                         !((HAS_SECURITY != 0) && eoi_nonsecure && !eoi_bank1);
  wire       wr_ok     = reg_wr && !ack_valid && !eoi_valid;
  wire       sel_g0    = (reg_addr[7:4] == 4'hD) && (reg_addr[1:0] == 2'b00);
  wire       sel_g1    = (reg_addr[7:4] == 4'hE) && (reg_addr[1:0] == 2'b00);
  wire [1:0] regno     = reg_addr[3:2];
  wire       ns        = (HAS_SECURITY != 0) && reg_nonsecure;
  wire       g1_open   = (HAS_GROUPS != 0) && !ns;

  always_comb begin
    logic done;
    logic [31:0] w;
    int tz;
    bank0_d = bank0_q;
    bank1_d = bank1_q;
    rp_d    = rp_q;
    done    = 1'b0;
    tz      = 0;
    if (ack_valid) begin
      for (int i = 0; i < NWORDS; i++)
        if (i == int'(level[7:5])) begin
          if (ack_bank1) bank1_d[i][level[4:0]] = 1'b1;
          else           bank0_d[i][level[4:0]] = 1'b1;
        end
      rp_d = {1'b0, gprio};
    end else if (eoi_ok) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (!done && eoi_bank1 && bank1_d[i] != 32'd0) begin
          bank1_d[i] = bank1_d[i] & (bank1_d[i] - 32'd1);
          done = 1'b1;
        end else if (!done && !eoi_bank1 && bank0_d[i] != 32'd0) begin
          bank0_d[i] = bank0_d[i] & (bank0_d[i] - 32'd1);
          done = 1'b1;
        end
      end
      done = 1'b0;
      rp_d = IDLE;
      for (int i = 0; i < NWORDS; i++) begin
        w = bank0_d[i] | bank1_d[i];
        if (!done && w != 32'd0) begin
          for (int b = 31; b >= 0; b--) if (w[b]) tz = b;
          rp_d = 9'((i * 32 + tz) << LVL_SHIFT);
          done = 1'b1;
        end
      end
    end else if (wr_ok) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (sel_g0 && !ns && i == int'(regno)) bank0_d[i] = reg_wdata;
        if (sel_g1 && g1_open && i == int'(regno)) bank1_d[i] = reg_wdata;
        if (sel_g0 && ns) begin
          case (MIN_BPR)
            0: if (regno < 2'd2 && i == int'(regno) + 2) bank1_d[i] = reg_wdata;
            1: if (regno == 2'd0 && i == 1) bank1_d[i] = reg_wdata;
            2: if (regno == 2'd0 && i == 0) bank1_d[i][31:16] = reg_wdata[15:0];
            default: if (regno == 2'd0 && i == 0) bank1_d[i][15:8] = reg_wdata[7:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata_d = 32'd0;
    if (reg_rd) begin
      for (int i = 0; i < NWORDS; i++) begin
        if (sel_g0 && !ns && i == int'(regno)) rdata_d = bank0_q[i];
        if (sel_g1 && g1_open && i == int'(regno)) rdata_d = bank1_q[i];
        if (sel_g0 && ns) begin
          case (MIN_BPR)
            0: if (regno < 2'd2 && i == int'(regno) + 2) rdata_d = bank1_q[i];
            1: if (regno == 2'd0 && i == 1) rdata_d = bank1_q[i];
            2: if (regno == 2'd0 && i == 0) rdata_d = {16'd0, bank1_q[i][31:16]};
            default: if (regno == 2'd0 && i == 0) rdata_d = {24'd0, bank1_q[i][15:8]};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) begin
        bank0_q[i] <= 32'd0;
        bank1_q[i] <= 32'd0;
      end
      rp_q    <= IDLE;
      rdata_q <= 32'd0;
    end else begin
      bank0_q <= bank0_d;
      bank1_q <= bank1_d;
      rp_q    <= rp_d;
      rdata_q <= rdata_d;
    end
  end

  assign run_prio  = rp_q;
  assign reg_rdata = rdata_q;

  AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> run_prio <= {1'b0, $past(ack_prio)}); // R2
  AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !run_prio[8]); // R4
  AST_RP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    run_prio != IDLE |-> (run_prio & LOWMASK) == 9'd0 && run_prio < IDLE); // R5
  AST_IDLE_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_valid && run_prio == IDLE) |=> run_prio == IDLE); // R6
  AST_NS_G0_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_valid && HAS_SECURITY != 0 && eoi_nonsecure &&
     !(HAS_GROUPS != 0 && eoi_group1)) |=> $stable(run_prio)); // R7
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == 32'd0); // R8
  AST_WR_KEEPS_RP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_valid && !eoi_valid) |=> $stable(run_prio)); // R11
endmodule

// File: tb/actprio_tracker_tb.sv
`timescale 1ns/1ps
module actprio_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_bpr = 3'd2, cfg_abpr = 3'd3;
  logic cfg_cbpr = 1'b0;
  logic ack_valid = 0, ack_group1 = 0, eoi_valid = 0, eoi_group1 = 0, eoi_nonsecure = 0;
  logic [7:0] ack_prio = 0;
  logic reg_wr = 0, reg_rd = 0, reg_nonsecure = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [8:0] run_prio;

  int checks = 0, errors = 0;
  logic [31:0] mb0 = 0, mb1 = 0;
  logic [8:0] mrp = 9'h100;

  always #2.5 clk = ~clk;

  actprio_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bpr(cfg_bpr), .cfg_abpr(cfg_abpr), .cfg_cbpr(cfg_cbpr),
    .ack_valid(ack_valid), .ack_prio(ack_prio), .ack_group1(ack_group1),
    .eoi_valid(eoi_valid), .eoi_group1(eoi_group1), .eoi_nonsecure(eoi_nonsecure),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_nonsecure(reg_nonsecure), .reg_rdata(reg_rdata), .run_prio(run_prio));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gprio(input logic [7:0] p, input logic g1);
    logic [2:0] b;
    b = (g1 && !cfg_cbpr) ? cfg_abpr : cfg_bpr;
    if (b < 3'd2) b = 3'd2;
    return p & (8'hFF << ({1'b0, b} + 4'd1));
  endfunction

  function automatic logic [8:0] rebuild();
    logic [31:0] w;
    w = mb0 | mb1;
    if (w == 0) return 9'h100;
    for (int b = 0; b < 32; b++) if (w[b]) return 9'(b << 3);
    return 9'h100;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic ns);
    if (a == 8'hD0) return ns ? {16'd0, mb1[31:16]} : mb0;
    if (a == 8'hE0) return ns ? 32'd0 : mb1;
    return 32'd0;
  endfunction

  task automatic step(input logic ack, input logic [7:0] ap, input logic ag,
                      input logic eoi, input logic eg, input logic ens,
                      input logic wr, input logic rd, input logic [7:0] a,
                      input logic [31:0] wd, input logic rns, input string req);
    logic [31:0] erd;
    logic [7:0] g;
    @(negedge clk);
    ack_valid = ack; ack_prio = ap; ack_group1 = ag;
    eoi_valid = eoi; eoi_group1 = eg; eoi_nonsecure = ens;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; reg_nonsecure = rns;
    erd = rd ? exp_rd(a, rns) : 32'd0;
    if (ack) begin
      g = gprio(ap, ag);
      if (ag) mb1[g[7:3]] = 1'b1; else mb0[g[7:3]] = 1'b1;
      mrp = {1'b0, g};
    end else if (eoi) begin
      if (mrp != 9'h100 && !(ens && !eg)) begin
        if (eg) mb1 = mb1 & (mb1 - 1); else mb0 = mb0 & (mb0 - 1);
        mrp = rebuild();
      end
    end else if (wr) begin
      if (a == 8'hD0 && !rns) mb0 = wd;
      else if (a == 8'hD0 && rns) mb1[31:16] = wd[15:0];
      else if (a == 8'hE0 && !rns) mb1 = wd;
    end
    @(negedge clk);
    ack_valid = 0; eoi_valid = 0; reg_wr = 0; reg_rd = 0;
    chk(req, {23'd0, run_prio}, {23'd0, mrp});
    if (rd) chk(req, reg_rdata, erd);
  endtask

  task automatic rd(input logic [7:0] a, input logic ns, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, a, 0, ns, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset prio", {23'd0, run_prio}, 32'h100);
    rd(8'hD0, 0, "R1 bank0 zero");
    rd(8'hE0, 0, "R1 bank1 zero");
    // R6: EOI while idle
    step(0, 0, 0, 1, 0, 0, 0, 1, 8'hD0, 0, 0, "R6 idle eoi");
    // R2 / R4: bpr 2 -> mask low 3 bits
    cfg_bpr = 3'd2; cfg_cbpr = 1'b1;
    step(1, 8'h47, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 R4 ack 0x47");
    rd(8'hD0, 0, "R4 bank0 bit 8");
    // R2: bp below minimum is clamped
    cfg_bpr = 3'd0;
    step(1, 8'h2F, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 clamp");
    // R2: bp 7 gives group priority 0
    cfg_bpr = 3'd7;
    step(1, 8'hFF, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 bp7");
    rd(8'hE0, 0, "R4 bank1 bit 0");
    // R3: alias used for group 1 only with cbpr clear
    cfg_bpr = 3'd2; cfg_abpr = 3'd4; cfg_cbpr = 1'b0;
    step(1, 8'hFF, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 alias g1");
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 g0 uses bpr");
    cfg_cbpr = 1'b1;
    step(1, 8'hE7, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 cbpr set");
    // R7: non-secure group-0 EOI ignored
    step(0, 0, 0, 1, 0, 1, 0, 1, 8'hD0, 0, 0, "R7 ns g0 eoi");
    // R5: drops
    step(0, 0, 0, 1, 1, 0, 0, 1, 8'hE0, 0, 0, "R5 drop g1");
    step(0, 0, 0, 1, 0, 0, 0, 1, 8'hD0, 0, 0, "R5 drop g0");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 1, k[0], 0, 0, 0, 0, 0, 0, "R5 drain");
    // R8 / R9 / R10 / R11 register port
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'hE0, 32'h0000_1234, 0, "R11 wr keeps prio");
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'hD0, 32'hFFFF_ABCD, 1, "R9 ns field write");
    rd(8'hE0, 0, "R9 low half kept");
    rd(8'hD0, 1, "R9 ns view");
    rd(8'hE0, 1, "R10 ns g1 zero");
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'hE0, 32'h5555_5555, 1, "R10 ns g1 write");
    rd(8'hE0, 0, "R10 write ignored");
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'hD4, 32'hFFFF_FFFF, 0, "R8 beyond words");
    rd(8'hD4, 0, "R8 beyond reads zero");
    rd(8'hD0, 0, "R8 bank0 intact");
    step(1, 8'h80, 0, 1, 0, 0, 1, 0, 8'hD0, 32'hDEAD_BEEF, 0, "R11 ack wins");
    rd(8'hD0, 0, "R11 write blocked");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      logic [7:0] a;
      op = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: a = 8'hD0; 1: a = 8'hE0; 2: a = 8'hD4; 3: a = 8'hEC; 4: a = 8'hE0; default: a = 8'h10;
      endcase
      cfg_bpr = 3'($urandom_range(0, 7)); cfg_abpr = 3'($urandom_range(0, 7));
      cfg_cbpr = 1'($urandom_range(0, 1));
      step(op < 3'd2, 8'($urandom), 1'($urandom), op == 3'd2 || op == 3'd3 || op == 3'd0,
           1'($urandom), op == 3'd3, op >= 3'd5 || op == 3'd2, 1'($urandom), a,
           (op == 3'd6) ? 32'd0 : $urandom, 1'($urandom), "R4 R5 R11 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
  end
endmodule